// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a common-I/O synchronous static RAM that takes commands on every rising clock edge and never needs an idle cycle when traffic switches between reads and writes. The address and all control inputs are registered. A read returns data through the array in the same cycle its address is registered, so the read path has no output register. A write registers its address on one edge and captures the bus data on the next edge. In that cycle the model leaves the shared data bus undriven, so the host can present the write data.

The word is 18 bits wide, split into two 9-bit lanes, and each lane has its own active-low write select. The depth is a parameter. A clock-enable input freezes the whole model. Three chip enables with mixed polarity decide whether a load command starts an access or deselects the device. Holding advance/load high steps a 2-bit linear burst counter, and the burst keeps its read or write type. An asynchronous output enable gates the read drivers.

Top module: `fts_sram`

## Requirements
- R1: After synchronous reset the model holds no access in progress, so `dq` is not driven even with `oe_n` low.
- R2: With `cen_n` high at a rising edge, no command is taken, no write data is captured, and the data on `dq` stays unchanged. A write that is waiting for its data captures the bus at the next edge that has `cen_n` low.
- R3: A load edge has `cen_n` low, `adv_ld_n` low, the chip selected and `we_n` high. After such an edge, and with `oe_n` low, `dq` carries the word stored at the registered address in the cycle that follows that edge.
- R4: While `oe_n` is high, `dq` is not driven. Lowering `oe_n` during a read cycle drives the read word without waiting for a clock edge.
- R5: A load edge with `we_n` low registers the address and the lane selects. At the next enabled edge the word on `dq` is written: `bw_n[0]` low writes bits 8:0 and `bw_n[1]` low writes bits 17:9.
- R6: A lane whose select was high keeps its previous contents.
- R7: In the cycle after a write address edge, `dq` is not driven, whatever the level of `oe_n`.
- R8: The chip counts as selected when `ce1_n` is low, `ce2` is high and `ce3_n` is low. If any one of the three is inactive at an enabled edge with `adv_ld_n` low, the device deselects and `dq` is released from the cycle after that edge.
- R9: A read loaded on the same edge that captures a previous write to that address returns the newly written word.
- R10: At an enabled edge with `adv_ld_n` high, an active access advances address bits 1:0 by one with wraparound inside its 4-word group and keeps its read or write type. The chip enables and `we_n` are ignored on such an edge. A deselected device stays deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable one, active low |
| ce2 | input | 1 | Chip enable two, active high |
| ce3_n | input | 1 | Chip enable three, active low |
| adv_ld_n | input | 1 | Low loads a new command, high advances the burst |
| we_n | input | 1 | Low selects a write at a load edge |
| bw_n | input | 2 | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | 18 | Shared bidirectional data bus |

## Verification
A corrupted operation register shows up on `dq` in the very next cycle. The bus is either driven when it should float, which shows as a read during a write data slot or after a deselect, or it floats when a read is due. A wrong address register or a wrong burst step gives a wrong but plausible word in the first cycle of that access. A dropped or mis-masked lane write stays hidden until that address is read back. For that reason the bench reads every written location back, including the lane that must not change.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int LANE_W  = 9;
    localparam int LANES   = 2;
    localparam int WORD_W  = LANE_W * LANES;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic hold;     // clock enable inactive
        logic load;     // advance/load low
        logic rd;       // write enable inactive
        logic sel;      // all chip enables active
    } ctl_t;

    function automatic logic chip_selected(input logic e1_n, input logic e2, input logic e3_n);
        return !e1_n && e2 && !e3_n;
    endfunction

    function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] cnt);
        return cnt + 1'b1;
    endfunction

endpackage

// File: rtl/fts_cmd.sv
module fts_cmd
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NLANE  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLANE-1:0]  bw_n,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [NLANE-1:0]  lane_q
);
    localparam int HI_W = ADDR_W - BURST_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            lane_q <= '0;
        end else if (!ctl.hold) begin
            lane_q <= ~bw_n;
            if (ctl.load) begin
                if (ctl.sel) begin
                    op_q   <= ctl.rd ? OP_READ : OP_WRITE;
                    addr_q <= addr;
                end else begin
                    op_q <= OP_IDLE;
                end
            end else if (op_q != OP_IDLE) begin
                addr_q <= {addr_q[ADDR_W-1 -: HI_W], burst_step(addr_q[BURST_W-1:0])};
            end
        end
    end

endmodule

// File: rtl/fts_array.sv
module fts_array
#(
    parameter int ADDR_W = 6,
    parameter int LW     = 9,
    parameter int NLANE  = 2
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [NLANE-1:0]    lane_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LW*NLANE-1:0] wr_data,
    output logic [LW*NLANE-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g])
                mem[addr] <= wr_data[g*LW +: LW];
        end

        assign rd_data[g*LW +: LW] = mem[addr];
    end

endmodule

// File: rtl/fts_io.sv
module fts_io
    import fts_pkg::*;
#(
    parameter int W = 18
) (
    input  op_e         op,
    input  logic        oe_n,
    input  logic [W-1:0] rd_data,
    output logic [W-1:0] bus_in,
    output logic        drv_en,
    inout  wire  [W-1:0] dq
);
    assign drv_en = (op == OP_READ) && !oe_n;
    assign dq     = drv_en ? rd_data : {W{1'bz}};
    assign bus_in = dq;

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic [1:0]        bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    inout  wire  [17:0]       dq
);
    ctl_t              ctl;
    logic              chip_sel;
    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_lanes;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] bus_word;
    logic              drv_en;
    logic              wr_fire;

    assign chip_sel = chip_selected(ce1_n, ce2, ce3_n);
    assign ctl      = '{hold: cen_n, load: !adv_ld_n, rd: we_n, sel: chip_sel};
    assign wr_fire  = !cen_n && (cur_op == OP_WRITE);

    fts_cmd #(.ADDR_W(ADDR_W), .NLANE(LANES)) u_cmd (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .addr   (addr),
        .bw_n   (bw_n),
        .op_q   (cur_op),
        .addr_q (cur_addr),
        .lane_q (cur_lanes)
    );

    fts_array #(.ADDR_W(ADDR_W), .LW(LANE_W), .NLANE(LANES)) u_array (
        .clk     (clk),
        .wr_en   (wr_fire),
        .lane_en (cur_lanes),
        .addr    (cur_addr),
        .wr_data (bus_word),
        .rd_data (rd_word)
    );

    fts_io #(.W(WORD_W)) u_io (
        .op      (cur_op),
        .oe_n    (oe_n),
        .rd_data (rd_word),
        .bus_in  (bus_word),
        .drv_en  (drv_en),
        .dq      (dq)
    );

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cen_n,
    input logic              adv_ld_n,
    input logic              we_n,
    input logic              sel,
    input logic [ADDR_W-1:0] addr,
    input logic              oe_n,
    input logic [1:0]        op,
    input logic [ADDR_W-1:0] addr_q,
    input logic              drv_en
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> op == 2'd0);

    // R2
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(op) && $stable(addr_q)));

    // R3
    read_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld_n && sel && we_n) |=> (op == 2'd1 && addr_q == $past(addr)));

    // R4
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drv_en);

    // R7
    write_float_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd2) |-> !drv_en);

    // R8
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld_n && !sel) |=> (op == 2'd0 && !drv_en));

    // R10
    burst_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && adv_ld_n && op != 2'd0) |=>
        (op == $past(op) && addr_q[1:0] == $past(addr_q[1:0]) + 2'd1));

endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cen_n    (cen_n),
    .adv_ld_n (adv_ld_n),
    .we_n     (we_n),
    .sel      (chip_sel),
    .addr     (addr),
    .oe_n     (oe_n),
    .op       (cur_op),
    .addr_q   (cur_addr),
    .drv_en   (drv_en)
);

// File: tb/fts_sram_tb.sv
module fts_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [17:0] FLOAT = 18'h3FFFF;

    logic       clk = 1'b0;
    logic       rst;
    logic       cen_n, ce1_n, ce2, ce3_n, adv_ld_n, we_n, oe_n;
    logic [1:0] bw_n;
    logic [5:0] addr;
    logic       tb_drv;
    logic [17:0] tb_dq;
    wire  [17:0] dq;

    int checks = 0;
    int errors = 0;

    assign dq = tb_drv ? tb_dq : {18{1'bz}};
    pullup p_dq [17:0] (dq);

    always #(CLK_PERIOD/2) clk = ~clk;

    fts_sram #(.ADDR_W(6)) u_dut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adv_ld_n(adv_ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .dq(dq)
    );

    // selm: 0 all enables active, 1/2/3 that chip enable inactive
    task automatic step(input logic cen, input int selm, input logic adv, input logic we,
                        input logic [1:0] bw, input logic [5:0] a, input logic drv,
                        input logic [17:0] d);
        cen_n    = cen;
        ce1_n    = (selm == 1);
        ce2      = (selm != 2);
        ce3_n    = (selm == 3);
        adv_ld_n = adv;
        we_n     = we;
        bw_n     = bw;
        addr     = a;
        tb_drv   = drv;
        tb_dq    = d;
        @(posedge clk);
        #1 tb_drv = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [17:0] exp);
        checks++;
        if (dq !== exp) begin
            errors++;
            $display("FAIL %s: dq=%h expected %h", req, dq, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [1:0] bw, input logic [17:0] d);
        step(0, 0, 0, 0, bw, a, 0, '0);
        step(0, 1, 0, 1, 2'b11, 0, 1, d);   // deselect while data is captured
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [17:0] exp);
        step(0, 0, 0, 1, 2'b11, a, 0, '0);
        chk(req, exp);
    endtask

    task automatic t_reset;
        oe_n = 1'b0;
        chk("R1 reset idle", FLOAT);
        step(0, 2, 0, 1, 2'b11, 0, 0, '0);
        chk("R1 idle after ce2 deselect", FLOAT);
    endtask

    task automatic t_write_read;
        wr(6'd5, 2'b00, 18'h12345);
        rd_chk("R3/R5 read full word", 6'd5, 18'h12345);
        wr(6'd9, 2'b00, 18'h0A0A5);
        rd_chk("R3 read second word", 6'd9, 18'h0A0A5);
        rd_chk("R3 reread first word", 6'd5, 18'h12345);
    endtask

    task automatic t_lanes;
        wr(6'd5, 2'b10, 18'h00077);
        rd_chk("R6 upper lane kept", 6'd5, {9'h091, 9'h077});
        wr(6'd5, 2'b01, 18'h15A00);
        rd_chk("R6 lower lane kept", 6'd5, {9'h0AD, 9'h077});
        wr(6'd5, 2'b11, 18'h00000);
        rd_chk("R6 no lane written", 6'd5, {9'h0AD, 9'h077});
    endtask

    task automatic t_oe;
        oe_n = 1'b1;
        step(0, 0, 0, 1, 2'b11, 6'd9, 0, '0);
        chk("R4 oe high floats", FLOAT);
        oe_n = 1'b0;
        #1 chk("R4 oe low drives without edge", 18'h0A0A5);
        oe_n = 1'b1;
        #1 chk("R4 oe high again", FLOAT);
        oe_n = 1'b0;
    endtask

    task automatic t_write_float;
        step(0, 0, 0, 0, 2'b00, 6'd12, 0, '0);
        chk("R7 write data slot floats", FLOAT);
        step(0, 3, 0, 1, 2'b11, 0, 1, 18'h01234);
        chk("R8 ce3 deselect floats", FLOAT);
        rd_chk("R5 written word", 6'd12, 18'h01234);
        step(0, 1, 0, 1, 2'b11, 0, 0, '0);
        chk("R8 ce1 deselect floats", FLOAT);
    endtask

    task automatic t_back_to_back;
        step(0, 0, 0, 0, 2'b00, 6'd20, 0, '0);
        step(0, 0, 0, 1, 2'b11, 6'd20, 1, 18'h2B3C4);
        chk("R9 read on capture edge", 18'h2B3C4);
        step(0, 0, 0, 0, 2'b00, 6'd21, 0, '0);
        chk("R7 float after read", FLOAT);
        step(0, 0, 0, 1, 2'b11, 6'd20, 1, 18'h01111);
        chk("R9 other address unchanged", 18'h2B3C4);
        rd_chk("R5 back-to-back write", 6'd21, 18'h01111);
    endtask

    task automatic t_hold;
        rd_chk("R2 setup read", 6'd20, 18'h2B3C4);
        step(1, 0, 0, 1, 2'b11, 6'd21, 0, '0);
        chk("R2 hold keeps read", 18'h2B3C4);
        step(0, 0, 0, 0, 2'b00, 6'd30, 0, '0);
        step(1, 0, 0, 1, 2'b11, 0, 1, 18'h00BAD);
        chk("R2 hold keeps write slot", FLOAT);
        step(0, 1, 0, 1, 2'b11, 0, 1, 18'h00C0D);
        rd_chk("R2 held data not captured", 6'd30, 18'h00C0D);
    endtask

    task automatic t_burst;
        step(0, 0, 0, 0, 2'b00, 6'd6, 0, '0);
        step(0, 1, 1, 1, 2'b00, 0, 1, 18'h00D00);
        step(0, 2, 1, 1, 2'b00, 0, 1, 18'h00D01);
        step(0, 3, 1, 1, 2'b00, 0, 1, 18'h00D02);
        step(0, 1, 0, 1, 2'b11, 0, 1, 18'h00D03);
        rd_chk("R10 burst start", 6'd7, 18'h00D01);
        step(0, 1, 1, 0, 2'b11, 0, 0, '0);
        chk("R10 wrap to 4 ignoring we and ce", 18'h00D02);
        step(0, 0, 1, 1, 2'b11, 0, 0, '0);
        chk("R10 step to 5", 18'h00D03);
        step(0, 0, 1, 1, 2'b11, 0, 0, '0);
        chk("R10 step to 6", 18'h00D00);
        step(0, 2, 0, 1, 2'b11, 0, 0, '0);
        step(0, 0, 1, 1, 2'b11, 6'd7, 0, '0);
        chk("R10 advance while deselected", FLOAT);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cen_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        adv_ld_n = 1'b0; we_n = 1'b1; bw_n = 2'b11; addr = '0; oe_n = 1'b0;
        tb_drv = 1'b0; tb_dq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_lanes();
        t_oe();
        t_write_float();
        t_back_to_back();
        t_hold();
        t_burst();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule